// File: doc/BRIEF.md
# DDS Pixel-Clock Oscillator

This block is the numerically controlled oscillator of a sampled phase-locked loop that rebuilds a pixel clock from a slow line reference. An N-bit phase accumulator runs on the fast system clock. On every cycle it adds the active control word and wraps modulo 2^N. The top bit of the accumulator is the recovered pixel clock. The whole accumulator value is also brought out so that a divider or a phase comparator can read the phase directly.

The active control word is a programmed centre value plus the signed correction from the loop filter, kept inside the range 1 to 2^N−1. The word is taken up only when the loop asserts its once-per-reference sample strobe. The frequency therefore stays constant over a whole reference period. From the loop's point of view the block is an integrator of frequency into phase with one sample of delay. When the loop has settled, the correction is chosen so that exactly 1312 pixel periods fit in one reference period. A registered one-cycle pulse marks each rising edge of the pixel clock for counters further down the chain.

Top module: `dds_pixel_dco`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator is cleared, `pix_clk` and `pix_rise` go low, the centre register takes `centre_in`, and `ctrl_word` takes `centre_in`, or 1 if `centre_in` is zero.
- R2: At every clock edge out of reset, `phase` becomes its previous value plus the `ctrl_word` that was present before that edge, modulo 2^N.
- R3: `ctrl_word` changes only at an edge where `sample_stb` is high. Changes on `loop_corr` without the strobe have no effect on `ctrl_word` or on the phase step.
- R4: At a strobe edge, `ctrl_word` becomes the centre register plus `loop_corr` read as two's complement and sign-extended. The result is visible from the next cycle.
- R5: When that sum is below 1, `ctrl_word` becomes 1.
- R6: When that sum is above 2^N−1, `ctrl_word` becomes 2^N−1.
- R7: A write through `centre_we` updates the centre register only. `ctrl_word` keeps its value until the next strobe, which uses the new centre.
- R8: `pix_clk` always equals bit N−1 of `phase`.
- R9: `pix_rise` is high for exactly the cycles in which `pix_clk` is 1 and was 0 in the cycle before.
- R10: With a constant word W, where W divides 2^N, a window of 1312·2^N/W cycles contains exactly 1312 `pix_rise` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| centre_in | input | ACC_W | Centre word value, loaded at reset or on write |
| centre_we | input | 1 | Writes `centre_in` into the centre register |
| sample_stb | input | 1 | Once-per-reference strobe that takes up a new control word |
| loop_corr | input | CORR_W | Signed loop-filter correction |
| phase | output | ACC_W | Current accumulator value |
| ctrl_word | output | ACC_W | Active frequency-control word |
| pix_clk | output | 1 | Recovered pixel clock (accumulator top bit) |
| pix_rise | output | 1 | One-cycle pulse on each pixel-clock rising edge |

## Verification
The hardest conditions to reach from the ports are the saturation limits and the exact 1312-to-1 period ratio. The stimulus reaches the limits by programming the centre register next to zero or next to 2^N−1. It then strobes corrections that land exactly on, one step inside, and well beyond each bound. For the ratio, the centre is set to power-of-two words whose pixel period divides the accumulator range evenly. Rising-edge pulses are then counted over a window of 1312 such periods. The result does not depend on the starting phase left by earlier tests.

// File: rtl/dco_pkg.sv
package dco_pkg;

    // Source of the next active control word
    typedef enum logic [1:0] {
        WSRC_HOLD   = 2'd0,
        WSRC_RESET  = 2'd1,
        WSRC_UPDATE = 2'd2
    } word_src_e;

    // Pixel-clock view of the accumulator
    typedef struct packed {
        logic level;
        logic rise;
    } pix_edge_t;

    function automatic logic up_edge(input logic was, input logic now);
        return (!was) && now;
    endfunction

    function automatic word_src_e pick_src(input logic rst_i, input logic stb_i);
        if (rst_i)
            return WSRC_RESET;
        else if (stb_i)
            return WSRC_UPDATE;
        else
            return WSRC_HOLD;
    endfunction

endpackage

// File: rtl/dco_word_ctrl.sv
module dco_word_ctrl #(
    parameter int ACC_W  = 32,
    parameter int CORR_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ACC_W-1:0]         centre_in,
    input  logic                     centre_we,
    input  logic                     sample_stb,
    input  logic signed [CORR_W-1:0] loop_corr,
    output logic [ACC_W-1:0]         word_q
);
    import dco_pkg::*;

    localparam int BASE_W = (ACC_W > CORR_W) ? ACC_W : CORR_W;
    localparam int SUM_W  = BASE_W + 2;

    logic [ACC_W-1:0]        centre_q;
    logic signed [SUM_W-1:0] sum_s;
    logic signed [SUM_W-1:0] top_s;
    logic signed [SUM_W-1:0] one_s;
    logic [ACC_W-1:0]        sat_word;
    logic [ACC_W-1:0]        boot_word;
    word_src_e               src;

    always_comb begin
        sum_s = $signed({{(SUM_W-ACC_W){1'b0}}, centre_q})
              + $signed({{(SUM_W-CORR_W){loop_corr[CORR_W-1]}}, loop_corr});
        top_s = $signed({{(SUM_W-ACC_W){1'b0}}, {ACC_W{1'b1}}});
        one_s = $signed({{(SUM_W-1){1'b0}}, 1'b1});
        if (sum_s < one_s)
            sat_word = {{(ACC_W-1){1'b0}}, 1'b1};
        else if (sum_s > top_s)
            sat_word = {ACC_W{1'b1}};
        else
            sat_word = sum_s[ACC_W-1:0];
    end

    assign boot_word = (centre_in == '0) ? {{(ACC_W-1){1'b0}}, 1'b1} : centre_in;
    assign src       = pick_src(rst, sample_stb);

    always_ff @(posedge clk) begin
        if (rst || centre_we)
            centre_q <= centre_in;
    end

    always_ff @(posedge clk) begin
        unique case (src)
            WSRC_RESET:  word_q <= boot_word;
            WSRC_UPDATE: word_q <= sat_word;
            default:     word_q <= word_q;
        endcase
    end

    // R3: the word only moves on a strobe edge
    assert_word_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(sample_stb) && !$past(rst)) |-> $stable(word_q));

    // R5: the word is never zero
    assert_word_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
        word_q != '0);

    // R7: a centre write alone leaves the word unchanged
    assert_centre_isolated_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(centre_we) && !$past(sample_stb) && !$past(rst)) |-> $stable(word_q));

endmodule

// File: rtl/dco_phase_acc.sv
module dco_phase_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] word,
    output logic [ACC_W-1:0] acc_q,
    output dco_pkg::pix_edge_t edge_o
);
    import dco_pkg::*;

    localparam int MSB = ACC_W - 1;

    logic [ACC_W-1:0] acc_nxt;
    logic             rise_q;

    assign acc_nxt = acc_q + word;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            rise_q <= 1'b0;
        end else begin
            acc_q  <= acc_nxt;
            rise_q <= up_edge(acc_q[MSB], acc_nxt[MSB]);
        end
    end

    assign edge_o.level = acc_q[MSB];
    assign edge_o.rise  = rise_q;

    // R2: phase advances by the previous word
    assert_phase_step_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (acc_q == $past(acc_q) + $past(word)));

    // R9: a pulse marks a fresh rising edge only
    assert_rise_edge_R9: assert property (@(posedge clk) disable iff (rst)
        (edge_o.rise && !$past(rst)) |-> (edge_o.level && !$past(edge_o.level)));

    // R9: pulses never last two cycles
    assert_rise_single_R9: assert property (@(posedge clk) disable iff (rst)
        edge_o.rise |=> !edge_o.rise);

endmodule

// File: rtl/dds_pixel_dco.sv
module dds_pixel_dco #(
    parameter int ACC_W  = 32,
    parameter int CORR_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ACC_W-1:0]         centre_in,
    input  logic                     centre_we,
    input  logic                     sample_stb,
    input  logic signed [CORR_W-1:0] loop_corr,
    output logic [ACC_W-1:0]         phase,
    output logic [ACC_W-1:0]         ctrl_word,
    output logic                     pix_clk,
    output logic                     pix_rise
);
    import dco_pkg::*;

    pix_edge_t pedge;

    dco_word_ctrl #(.ACC_W(ACC_W), .CORR_W(CORR_W)) u_word (
        .clk        (clk),
        .rst        (rst),
        .centre_in  (centre_in),
        .centre_we  (centre_we),
        .sample_stb (sample_stb),
        .loop_corr  (loop_corr),
        .word_q     (ctrl_word)
    );

    dco_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .word   (ctrl_word),
        .acc_q  (phase),
        .edge_o (pedge)
    );

    assign pix_clk  = pedge.level;
    assign pix_rise = pedge.rise;

    // R8: output clock tracks the phase top bit
    assert_clk_is_msb_R8: assert property (@(posedge clk) disable iff (rst)
        pix_clk == phase[ACC_W-1]);

endmodule

// File: tb/sim_dds_pixel_dco.sv
module sim_dds_pixel_dco;
    localparam int AW = 32;
    localparam int CW = 16;

    logic                  clk = 1'b0;
    logic                  rst;
    logic [AW-1:0]         centre_in;
    logic                  centre_we;
    logic                  sample_stb;
    logic signed [CW-1:0]  loop_corr;
    logic [AW-1:0]         phase;
    logic [AW-1:0]         ctrl_word;
    logic                  pix_clk;
    logic                  pix_rise;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dds_pixel_dco #(.ACC_W(AW), .CORR_W(CW)) u0 (
        .clk(clk), .rst(rst), .centre_in(centre_in), .centre_we(centre_we),
        .sample_stb(sample_stb), .loop_corr(loop_corr), .phase(phase),
        .ctrl_word(ctrl_word), .pix_clk(pix_clk), .pix_rise(pix_rise)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_centre(input logic [AW-1:0] v);
        centre_in = v;
        centre_we = 1'b1;
        @(negedge clk);
        centre_we = 1'b0;
    endtask

    task automatic strobe(input int c);
        sample_stb = 1'b1;
        loop_corr  = CW'(c);
        @(negedge clk);
        sample_stb = 1'b0;
        loop_corr  = '0;
    endtask

    task automatic t_reset;
        chk(phase == '0, "R1 phase", phase, 0);
        chk(pix_clk == 1'b0 && pix_rise == 1'b0, "R1 outputs", {pix_clk, pix_rise}, 0);
        chk(ctrl_word == 32'h0123_4567, "R1 word", ctrl_word, 32'h0123_4567);
    endtask

    task automatic t_step;
        for (int i = 0; i < 3; i++) begin
            logic [AW-1:0] p0;
            p0 = phase;
            @(negedge clk);
            chk(phase == p0 + 32'h0123_4567, "R2 step", phase, p0 + 32'h0123_4567);
        end
    endtask

    task automatic t_centre_and_neg;
        logic [AW-1:0] p0;
        write_centre(32'd1000);
        chk(ctrl_word == 32'h0123_4567, "R7 word held after centre write", ctrl_word, 32'h0123_4567);
        @(negedge clk);
        chk(ctrl_word == 32'h0123_4567, "R7 word still held", ctrl_word, 32'h0123_4567);
        strobe(-300);
        chk(ctrl_word == 32'd700, "R4 negative correction", ctrl_word, 700);
        p0 = phase;
        @(negedge clk);
        chk(phase == p0 + 32'd700, "R2 step with new word", phase, p0 + 32'd700);
        strobe(250);
        chk(ctrl_word == 32'd1250, "R4 positive correction", ctrl_word, 1250);
    endtask

    task automatic t_hold;
        logic [AW-1:0] p0;
        loop_corr = 16'sh7FFF;
        for (int i = 0; i < 5; i++) begin
            p0 = phase;
            @(negedge clk);
            chk(ctrl_word == 32'd1250, "R3 word unchanged without strobe", ctrl_word, 1250);
            chk(phase == p0 + 32'd1250, "R3 phase step unchanged", phase, p0 + 32'd1250);
        end
        loop_corr = '0;
    endtask

    task automatic t_clamp_lo;
        write_centre(32'd5);
        strobe(-100);
        chk(ctrl_word == 32'd1, "R5 clamp far below", ctrl_word, 1);
        strobe(-5);
        chk(ctrl_word == 32'd1, "R5 clamp sum zero", ctrl_word, 1);
        strobe(-4);
        chk(ctrl_word == 32'd1, "R5 sum exactly one", ctrl_word, 1);
        strobe(-3);
        chk(ctrl_word == 32'd2, "R5 just inside", ctrl_word, 2);
    endtask

    task automatic t_clamp_hi;
        write_centre(32'hFFFF_FFF0);
        strobe(100);
        chk(ctrl_word == 32'hFFFF_FFFF, "R6 clamp far above", ctrl_word, 32'hFFFF_FFFF);
        strobe(16);
        chk(ctrl_word == 32'hFFFF_FFFF, "R6 clamp one over", ctrl_word, 32'hFFFF_FFFF);
        strobe(15);
        chk(ctrl_word == 32'hFFFF_FFFF, "R6 sum at top", ctrl_word, 32'hFFFF_FFFF);
        strobe(14);
        chk(ctrl_word == 32'hFFFF_FFFE, "R6 just inside", ctrl_word, 32'hFFFF_FFFE);
    endtask

    task automatic t_edges;
        logic prev;
        write_centre(32'h1000_0000);
        strobe(0);
        prev = pix_clk;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            chk(pix_clk == phase[AW-1], "R8 clock is top bit", pix_clk, phase[AW-1]);
            chk(pix_rise == (pix_clk && !prev), "R9 rise pulse", pix_rise, (pix_clk && !prev));
            prev = pix_clk;
        end
    endtask

    task automatic count_window(input logic [AW-1:0] w, input int cycles);
        int n;
        write_centre(w);
        strobe(0);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (pix_rise) n++;
        end
        chk(n == 1312, "R10 rises per reference period", n, 1312);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst        = 1'b1;
        centre_in  = 32'h0123_4567;
        centre_we  = 1'b0;
        sample_stb = 1'b0;
        loop_corr  = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset;
        rst = 1'b0;
        t_step;
        t_centre_and_neg;
        t_hold;
        t_clamp_lo;
        t_clamp_hi;
        t_edges;
        count_window(32'h1000_0000, 1312 * 16);
        count_window(32'h0800_0000, 1312 * 32);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule